// File: doc/BRIEF.md
# PTP Time-of-Day Clock with Fractional Rate Trim

This block keeps an IEEE 1588 time of day in three fields: a 32-bit seconds count, a nanoseconds count that rolls over at one billion, and a 32-bit binary fraction of a nanosecond. A tick strobe arrives at 25 MHz. Each tick accepted while the clock runs moves the time forward by a nominal 40 ns. A trim magnitude with a direction bit can add to or take from the fraction on every tick. Carries and borrows out of the fraction change the nanosecond step by one, which lets a servo correct the frequency of the clock in very fine steps.

Control comes through single-cycle command pulses. A snapshot command copies the live time into read-back registers. The snapshot also records a small phase count, the number of core clocks since the last tick. A load command writes the set-value inputs into the live clock and clears the fraction. A step command adds the set values to the time, or takes them away, with carry or borrow across the seconds boundary. Each command takes effect at the next clock edge.

Top module: `ptp_tod_clock`

## Requirements
- R1: After reset, the live seconds, live nanoseconds, fraction, snapshot outputs and phase are all zero.
- R2: A tick_i pulse with run_en_i high adds 40 ns to the time at the next clock edge. With run_en_i low, or with no tick and no command, the live time does not change.
- R3: Nanoseconds stay below 1,000,000,000 and carry into seconds when they pass that value. Seconds wrap modulo 2^32.
- R4: A load_i pulse makes the live time equal to set_sec_i/set_ns_i at the next edge and clears the fraction. Load takes priority over a step or tick in the same cycle.
- R5: A snap_i pulse captures the live seconds and nanoseconds as they were before that edge. The captured values hold until the next snap_i.
- R6: The phase count is cleared in a cycle with tick_i high. It counts core clock cycles after that and saturates at 7. snap_i captures it on snap_phase_o.
- R7: step_i with step_add_i=1 adds set_sec_i and set_ns_i (set_ns_i < 1e9) to the time, carrying into seconds. A tick in the same cycle is applied first.
- R8: step_i with step_add_i=0 subtracts set_sec_i and set_ns_i, borrowing one second when nanoseconds would go negative.
- R9: With trim_en_i high, each accepted tick adds trim_mag_i to the fraction when trim_up_i=1, or subtracts it when trim_up_i=0. A carry out adds 1 ns to that tick's step and a borrow takes 1 ns away. With mag 2^29, eight ticks from a cleared fraction advance 321 ns (up) or 319 ns (down).
- R10: With trim_en_i low, every accepted tick advances exactly 40 ns, whatever trim_mag_i holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 25 MHz time-step strobe, one core cycle wide |
| run_en_i | input | 1 | Clock runs on ticks when high |
| trim_en_i | input | 1 | Applies the fractional rate trim |
| trim_up_i | input | 1 | Trim direction: 1 speeds the clock up, 0 slows it down |
| trim_mag_i | input | 30 | Trim magnitude per tick, in units of 2^-32 ns |
| set_sec_i | input | 32 | Seconds value for load or step |
| set_ns_i | input | 30 | Nanoseconds value for load or step |
| load_i | input | 1 | Load command pulse |
| step_i | input | 1 | Step command pulse |
| step_add_i | input | 1 | Step direction: 1 adds, 0 subtracts |
| snap_i | input | 1 | Snapshot command pulse |
| now_sec_o | output | 32 | Live seconds |
| now_ns_o | output | 30 | Live nanoseconds |
| snap_sec_o | output | 32 | Captured seconds |
| snap_ns_o | output | 30 | Captured nanoseconds |
| snap_phase_o | output | 3 | Captured phase count |

## Verification
Every input and command is registered exactly once, so the live time, snapshot values and phase are all due one clock edge after the cycle in which the stimulus is sampled. The bench drives stimulus on falling edges and holds each pulse for one cycle. It raises its compare event on the falling edge that follows the capturing rising edge. For the phase, it counts the rising edges between the end of a tick and the snapshot to get the expected value. Expected times come from a bench model that keeps the fraction as a 64-bit integer and applies tick, step and load in the order the requirements give.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
  localparam int SEC_W = 32;
  localparam int NS_W  = 30;
  localparam logic [NS_W:0] NS_PER_SEC = 31'd1_000_000_000;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [NS_W-1:0]  ns;
  } tod_t;
endpackage

// File: rtl/ptp_tick_adv.sv
module ptp_tick_adv
  import ptp_tod_pkg::*;
#(
  parameter int FRAC_W = 32,
  parameter int RATE_W = 30,
  parameter int INC_NS = 40
) (
  input  tod_t              tod_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              adv_i,
  input  logic              trim_en_i,
  input  logic              trim_up_i,
  input  logic [RATE_W-1:0] trim_mag_i,
  output tod_t              tod_o,
  output logic [FRAC_W-1:0] frac_o
);
  localparam int PAD_W = FRAC_W + 1 - RATE_W;

  logic [FRAC_W:0] frac_ext;
  logic [FRAC_W:0] mag_ext;
  logic [FRAC_W:0] fsum;
  logic [NS_W:0]   inc;
  logic [NS_W:0]   ns_sum;

  assign frac_ext = {1'b0, frac_i};
  assign mag_ext  = {{PAD_W{1'b0}}, trim_mag_i};

  always_comb begin
    fsum   = frac_ext;
    inc    = '0;
    frac_o = frac_i;
    if (adv_i) begin
      inc = (NS_W+1)'(INC_NS);
      if (trim_en_i) begin
        // top bit of fsum is the carry (up) or borrow (down)
        if (trim_up_i) begin
          fsum = frac_ext + mag_ext;
          inc  = inc + (NS_W+1)'(fsum[FRAC_W]);
        end else begin
          fsum = frac_ext - mag_ext;
          inc  = inc - (NS_W+1)'(fsum[FRAC_W]);
        end
        frac_o = fsum[FRAC_W-1:0];
      end
    end
  end

  always_comb begin
    ns_sum = {1'b0, tod_i.ns} + inc;
    tod_o  = tod_i;
    if (ns_sum >= NS_PER_SEC) begin
      ns_sum    = ns_sum - NS_PER_SEC;
      tod_o.sec = tod_i.sec + 1'b1;
    end
    tod_o.ns = ns_sum[NS_W-1:0];
  end
endmodule

// File: rtl/ptp_step_unit.sv
module ptp_step_unit
  import ptp_tod_pkg::*;
(
  input  tod_t             tod_i,
  input  logic [SEC_W-1:0] off_sec_i,
  input  logic [NS_W-1:0]  off_ns_i,
  input  logic             add_i,
  output tod_t             tod_o
);
  logic [NS_W:0] ns_t;

  always_comb begin
    tod_o = tod_i;
    if (add_i) begin
      ns_t = {1'b0, tod_i.ns} + {1'b0, off_ns_i};
      if (ns_t >= NS_PER_SEC) begin
        ns_t      = ns_t - NS_PER_SEC;
        tod_o.sec = tod_i.sec + off_sec_i + 1'b1;
      end else begin
        tod_o.sec = tod_i.sec + off_sec_i;
      end
    end else begin
      ns_t = {1'b0, tod_i.ns} - {1'b0, off_ns_i};
      if (ns_t[NS_W]) begin
        ns_t      = ns_t + NS_PER_SEC;
        tod_o.sec = tod_i.sec - off_sec_i - 1'b1;
      end else begin
        tod_o.sec = tod_i.sec - off_sec_i;
      end
    end
    tod_o.ns = ns_t[NS_W-1:0];
  end
endmodule

// File: rtl/ptp_phase_cnt.sv
module ptp_phase_cnt #(
  parameter int PHASE_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  output logic [PHASE_W-1:0] phase_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               phase_o <= '0;
    else if (tick_i)           phase_o <= '0;
    else if (phase_o != '1)    phase_o <= phase_o + 1'b1;
  end

  // R6
  tick_clears_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (phase_o == '0));
endmodule

// File: rtl/ptp_tod_clock.sv
module ptp_tod_clock
  import ptp_tod_pkg::*;
#(
  parameter int FRAC_W  = 32,
  parameter int RATE_W  = 30,
  parameter int INC_NS  = 40,
  parameter int PHASE_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               run_en_i,
  input  logic               trim_en_i,
  input  logic               trim_up_i,
  input  logic [RATE_W-1:0]  trim_mag_i,
  input  logic [SEC_W-1:0]   set_sec_i,
  input  logic [NS_W-1:0]    set_ns_i,
  input  logic               load_i,
  input  logic               step_i,
  input  logic               step_add_i,
  input  logic               snap_i,
  output logic [SEC_W-1:0]   now_sec_o,
  output logic [NS_W-1:0]    now_ns_o,
  output logic [SEC_W-1:0]   snap_sec_o,
  output logic [NS_W-1:0]    snap_ns_o,
  output logic [PHASE_W-1:0] snap_phase_o
);
  tod_t              tod_q, tod_d, tod_adv, tod_stp;
  logic [FRAC_W-1:0] frac_q, frac_d, frac_adv;
  logic [PHASE_W-1:0] phase;
  logic              adv;

  assign adv = tick_i & run_en_i;

  ptp_tick_adv #(.FRAC_W(FRAC_W), .RATE_W(RATE_W), .INC_NS(INC_NS)) u_adv (
    .tod_i(tod_q), .frac_i(frac_q), .adv_i(adv),
    .trim_en_i(trim_en_i), .trim_up_i(trim_up_i), .trim_mag_i(trim_mag_i),
    .tod_o(tod_adv), .frac_o(frac_adv)
  );

  ptp_step_unit u_step (
    .tod_i(tod_adv), .off_sec_i(set_sec_i), .off_ns_i(set_ns_i),
    .add_i(step_add_i), .tod_o(tod_stp)
  );

  ptp_phase_cnt #(.PHASE_W(PHASE_W)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .phase_o(phase)
  );

  always_comb begin
    tod_d  = tod_adv;
    frac_d = frac_adv;
    if (load_i) begin
      tod_d.sec = set_sec_i;
      tod_d.ns  = set_ns_i;
      frac_d    = '0;
    end else if (step_i) begin
      tod_d = tod_stp;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tod_q  <= '0;
      frac_q <= '0;
    end else begin
      tod_q  <= tod_d;
      frac_q <= frac_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_sec_o   <= '0;
      snap_ns_o    <= '0;
      snap_phase_o <= '0;
    end else if (snap_i) begin
      snap_sec_o   <= tod_q.sec;
      snap_ns_o    <= tod_q.ns;
      snap_phase_o <= phase;
    end
  end

  assign now_sec_o = tod_q.sec;
  assign now_ns_o  = tod_q.ns;

  // R3
  ns_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tod_q.ns < NS_PER_SEC);

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv && !load_i && !step_i) |=> ($stable(tod_q) && $stable(frac_q)));

  // R4
  load_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (tod_q.sec == $past(set_sec_i) && tod_q.ns == $past(set_ns_i)
                && frac_q == '0));

  // R5
  snap_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_i |=> (snap_sec_o == $past(tod_q.sec) && snap_ns_o == $past(tod_q.ns)));

  // R5
  snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> ($stable(snap_sec_o) && $stable(snap_ns_o) && $stable(snap_phase_o)));
endmodule

// File: tb/sim_ptp_tod_clock.sv
module sim_ptp_tod_clock;
  localparam longint NS1 = 1_000_000_000;
  localparam longint F1  = 64'h1_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 0, run_en = 0, trim_en = 0, trim_up = 0;
  logic [29:0] trim_mag = '0;
  logic [31:0] set_sec = '0;
  logic [29:0] set_ns = '0;
  logic        load = 0, step = 0, step_add = 0, snap = 0;
  logic [31:0] now_sec, snap_sec;
  logic [29:0] now_ns, snap_ns;
  logic [2:0]  snap_phase;

  always #10 clk = ~clk;

  ptp_tod_clock u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .run_en_i(run_en),
    .trim_en_i(trim_en), .trim_up_i(trim_up), .trim_mag_i(trim_mag),
    .set_sec_i(set_sec), .set_ns_i(set_ns), .load_i(load), .step_i(step),
    .step_add_i(step_add), .snap_i(snap),
    .now_sec_o(now_sec), .now_ns_o(now_ns), .snap_sec_o(snap_sec),
    .snap_ns_o(snap_ns), .snap_phase_o(snap_phase)
  );

  typedef struct {
    string  tag;
    int     kind;   // 0 live, 1 snapshot time, 2 snapshot phase
    longint a;
    longint b;
  } exp_t;

  exp_t   sb[$];
  event   chk_ev;
  int     total = 0, bad = 0;
  bit     done = 0;
  longint m_sec = 0, m_ns = 0, m_frac = 0;

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(chk_ev);
      while (sb.size() > 0) begin
        exp_t e;
        longint as_, an;
        e = sb.pop_front();
        total++;
        case (e.kind)
          0: begin as_ = longint'(now_sec);  an = longint'(now_ns);  end
          1: begin as_ = longint'(snap_sec); an = longint'(snap_ns); end
          default: begin as_ = longint'(snap_phase); an = 0; end
        endcase
        if (as_ != e.a || an != e.b) begin
          bad++;
          $display("FAIL %s: actual %0d/%0d expected %0d/%0d", e.tag, as_, an, e.a, e.b);
        end
      end
    end
  end

  task automatic push(string tag, int kind, longint a, longint b);
    exp_t e;
    e.tag = tag; e.kind = kind; e.a = a; e.b = b;
    sb.push_back(e);
    -> chk_ev;
    #0;
  endtask

  task automatic model_tick();
    longint extra = 0;
    if (!run_en) return;
    if (trim_en) begin
      m_frac = trim_up ? m_frac + longint'(trim_mag) : m_frac - longint'(trim_mag);
      if (m_frac >= F1) begin m_frac -= F1; extra = 1; end
      else if (m_frac < 0) begin m_frac += F1; extra = -1; end
    end
    m_ns += 40 + extra;
    if (m_ns >= NS1) begin m_ns -= NS1; m_sec = (m_sec + 1) & 64'hFFFF_FFFF; end
  endtask

  task automatic model_step(longint s, longint n, bit add);
    if (add) begin
      m_ns += n; m_sec += s;
      if (m_ns >= NS1) begin m_ns -= NS1; m_sec++; end
    end else begin
      m_ns -= n; m_sec -= s;
      if (m_ns < 0) begin m_ns += NS1; m_sec--; end
    end
    m_sec &= 64'hFFFF_FFFF;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
      model_tick();
    end
  endtask

  task automatic do_load(longint s, longint n, bit with_tick);
    @(negedge clk);
    set_sec = 32'(s); set_ns = 30'(n); load = 1; tick = with_tick;
    @(negedge clk);
    load = 0; tick = 0;
    m_sec = s; m_ns = n; m_frac = 0;
  endtask

  task automatic do_step(longint s, longint n, bit add, bit with_tick);
    @(negedge clk);
    set_sec = 32'(s); set_ns = 30'(n); step = 1; step_add = add; tick = with_tick;
    @(negedge clk);
    step = 0; tick = 0;
    if (with_tick) model_tick();
    model_step(s, n, add);
  endtask

  task automatic do_snap(int idle, string tag);
    int ph;
    repeat (idle) @(negedge clk);
    snap = 1;
    @(negedge clk);
    snap = 0;
    ph = idle > 7 ? 7 : idle;
    push({tag, " time"}, 1, m_sec, m_ns);
    push({tag, " phase"}, 2, longint'(ph), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    push("R1 live reset", 0, 0, 0);
    push("R1 snap reset", 1, 0, 0);
    push("R6 phase reset", 2, 0, 0);
    rst_n = 1;

    // R2 ticks ignored while not running
    ticks(5);
    push("R2 run_en low", 0, 0, 0);
    run_en = 1;
    ticks(3);
    push("R2 three ticks", 0, 0, 120);

    // R3 carry into seconds
    do_load(5, 999_999_960, 0);
    push("R4 load", 0, 5, 999_999_960);
    ticks(1);
    push("R3 ns carry", 0, 6, 0);
    do_load(64'hFFFF_FFFF, 999_999_960, 0);
    ticks(1);
    push("R3 seconds wrap", 0, 0, 0);

    // R4 load beats simultaneous tick
    do_load(77, 1234, 1);
    push("R4 load over tick", 0, 77, 1234);

    // R5/R6 snapshot and phase
    ticks(2);
    do_snap(2, "R5 R6 snap idle2");
    do_snap(12, "R5 R6 snap idle12");
    ticks(1);
    do_snap(0, "R6 snap idle0");
    ticks(4);
    push("R5 snap held", 1, 77, 1234 + 120);

    // R7 step add with carry
    do_load(1, 600_000_000, 0);
    do_step(2, 500_000_000, 1, 0);
    push("R7 step add carry", 0, 4, 100_000_000);
    do_step(1, 10, 1, 1);
    push("R7 step add with tick", 0, 5, 100_000_050);

    // R8 step subtract with borrow
    do_load(10, 100_000_000, 0);
    do_step(3, 300_000_000, 0, 0);
    push("R8 step sub borrow", 0, 6, 800_000_000);
    do_step(0, 800_000_000, 0, 1);
    push("R8 step sub with tick", 0, 6, 40);

    // R9 trim up / down, mag 2^29
    trim_mag = 30'h2000_0000;
    trim_en = 1; trim_up = 1;
    do_load(0, 0, 0);
    ticks(8);
    push("R9 trim up 8 ticks", 0, 0, 321);
    trim_up = 0;
    do_load(0, 0, 0);
    ticks(8);
    push("R9 trim down 8 ticks", 0, 0, 319);

    // R4 load clears fraction
    trim_up = 1;
    do_load(0, 0, 0);
    ticks(4);
    do_load(0, 0, 0);
    ticks(4);
    push("R4 frac cleared", 0, 0, 160);

    // R10 trim disabled
    trim_en = 0;
    do_load(3, 0, 0);
    ticks(8);
    push("R10 trim off", 0, 3, 320);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100_000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule